// File: doc/BRIEF.md
# PLL Configuration Sequencer

This block is a control state machine that brings a frequency synthesizer to a new operating point when it is asked to. A request carries the target VCO frequency in MHz, the integer and fractional feedback divider values, a pre-divider and the parent clock rate in kHz. The sequencer first checks that the request is in range. It then works out the loop-filter gains from the VCO band and from the reference band. After that it steps the synthesizer's control pins through a fixed ordering, with one action per clock cycle. When the resets are released, it polls a lock input at a fixed interval with a capped number of tries.

The reference frequency is the parent rate divided by the pre-divider, and a pre-divider of zero doubles the parent rate instead. A separate disable request powers the synthesizer down in an isolation-safe order. An always-on build ignores that request. Completion is signalled by a one-cycle `done` pulse. Every failure is signalled by a one-cycle `err` pulse together with a held error code.

Top module: `pll_cfg_seq`

## Requirements
- R1: A target below 700 MHz or at or above 4000 MHz ends the request with an `err` pulse and `err_code` = 1, and no control output changes.
- R2: The reference in kHz is parent/pre-divider, or parent×2 when the pre-divider is 0. A reference below 10000 kHz or at or above 125000 kHz ends the request with `err_code` = 2 and no control output changes.
- R3: `ki_o` is 4 for targets in [700, 2200) MHz and 3 for [2200, 4000) MHz. `ka_o` is always 0.
- R4: `kp_o` comes from a table. The row is set by the target: mid for [700, 2200), high for [2200, 3100), top for [3100, 4000). The column is the reference band, with upper edges at 12500, 15000, 20000, 25000, 50000, 75000 and 100000 kHz. Mid row: 5,6,6,7,7,8,9,10. High row: 4,4,5,5,6,7,8,9. Top row: 4,5,5,6,7,8,9,10.
- R5: `vco_low_rng` is 1 exactly for targets in [700, 1200) MHz. `vco_high_rng` is 1 exactly for targets at or above 2200 MHz.
- R6: A valid request runs the following steps in order, one step per cycle:
  1. Raise power and clear isolation.
  2. Raise the gate.
  3. Drive both resets low.
  4. Pulse `vco_hi_clr`.
  5. Set the range bits.
  6. Load the dividers.
  7. Load the gains.
  8. Release both resets.
- R7: Lock is sampled every WAIT_CYC cycles after reset release. `done` rises on the first sample that sees lock. If no lock is seen in LOCK_TRIES samples, the request ends with `err_code` = 3, LOCK_TRIES×WAIT_CYC cycles after release.
- R8: A disable request runs three steps in order: drop the gate, raise isolation, then drop power. It then ends with a `done` pulse.
- R9: With ALWAYS_ON = 1, a disable request is ignored: power stays on and `busy` stays low.
- R10: Requests are accepted only when idle. `busy` is high from acceptance until the completing pulse. `done` and `err` last one cycle.
- R11: The divider outputs take the requested values. The fractional output is loaded only when HAS_FRAC = 1 and otherwise stays 0.
- R12: After reset: power off, isolation on, gate off, both resets low, gains and range bits 0, `busy`/`done`/`err` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_req | input | 1 | Start a reconfiguration |
| dis_req | input | 1 | Start a power-down |
| tgt_mhz | input | TGT_W | Target VCO frequency, MHz |
| fb_int | input | NINT_W | Integer feedback divider |
| fb_frac | input | NFRAC_W | Fractional feedback divider |
| pre_div | input | PDIV_W | Pre-divider (0 doubles) |
| parent_khz | input | PAR_W | Parent clock rate, kHz |
| lock_in | input | 1 | Lock indication from synthesizer |
| pwr_on | output | 1 | Core power enable |
| iso_on | output | 1 | Input isolation latch |
| gate_en | output | 1 | Top-level output gate |
| rst_main_n | output | 1 | Main reset, active low |
| rst_post_n | output | 1 | Post-divider reset, active low |
| vco_hi_clr | output | 1 | One-cycle clear of the upper VCO control word |
| vco_low_rng | output | 1 | VCO low-range select |
| vco_high_rng | output | 1 | VCO high-range select |
| fb_int_o | output | NINT_W | Loaded integer divider |
| fb_frac_o | output | NFRAC_W | Loaded fractional divider |
| pre_div_o | output | PDIV_W | Loaded pre-divider |
| kp_o | output | 4 | Proportional gain |
| ki_o | output | 3 | Integral gain |
| ka_o | output | 3 | Auxiliary gain |
| busy | output | 1 | Request in progress |
| done | output | 1 | Success pulse |
| err | output | 1 | Failure pulse |
| err_code | output | 2 | Last result: 0 ok, 1 range, 2 reference, 3 lock timeout |

## Verification
The bench builds two copies that share all inputs. One uses WAIT_CYC = 3, LOCK_TRIES = 12, HAS_FRAC = 1 and ALWAYS_ON = 0. The other keeps the same timing but sets HAS_FRAC = 0 and ALWAYS_ON = 1, so the unloaded fractional path and the ignored disable are both observed. The short interval and low try count put a full lock timeout, and a lock that first appears on the last allowed sample, within a few dozen cycles. That makes exact sample timing checkable on both sides of the cap.

// File: rtl/pll_cfg_seq_pkg.sv
// Package: shared types, band edges and the proportional-gain table.
// Assumes frequencies in MHz for the VCO target and kHz for the reference.
package pll_cfg_seq_pkg;

    localparam int KP_W = 4;
    localparam int KI_W = 3;
    localparam int KA_W = 3;

    localparam int VCO_MIN_MHZ  = 700;
    localparam int VCO_LOW_MHZ  = 1200;
    localparam int VCO_HIGH_MHZ = 2200;
    localparam int VCO_TOP_MHZ  = 3100;
    localparam int VCO_MAX_MHZ  = 4000;

    localparam logic [1:0] ERR_NONE = 2'd0;
    localparam logic [1:0] ERR_VCO  = 2'd1;
    localparam logic [1:0] ERR_REF  = 2'd2;
    localparam logic [1:0] ERR_LOCK = 2'd3;

    typedef enum logic [3:0] {
        ST_IDLE, ST_CHECK, ST_PWR, ST_GATE, ST_RST, ST_VCLR, ST_VRNG,
        ST_DIV, ST_GAIN, ST_REL, ST_WAIT, ST_PD_GATE, ST_PD_ISO, ST_PD_PWR
    } seq_state_t;

    typedef enum logic [1:0] {ROW_MID = 2'd0, ROW_HIGH = 2'd1, ROW_TOP = 2'd2} gain_row_t;

    // Column 0 in the low nibble.
    localparam logic [31:0] KP_ROW_MID  = {4'd10, 4'd9, 4'd8, 4'd7, 4'd7, 4'd6, 4'd6, 4'd5};
    localparam logic [31:0] KP_ROW_HIGH = {4'd9,  4'd8, 4'd7, 4'd6, 4'd5, 4'd5, 4'd4, 4'd4};
    localparam logic [31:0] KP_ROW_TOP  = {4'd10, 4'd9, 4'd8, 4'd7, 4'd6, 4'd5, 4'd5, 4'd4};

    // Proportional gain for a row and a reference column.
    function automatic logic [KP_W-1:0] kp_lookup(gain_row_t row, logic [2:0] col);
        logic [31:0] tbl;
        case (row)
            ROW_MID:  tbl = KP_ROW_MID;
            ROW_HIGH: tbl = KP_ROW_HIGH;
            default:  tbl = KP_ROW_TOP;
        endcase
        return tbl[{col, 2'b00} +: KP_W];
    endfunction

    // Reference band edges in kHz; edge 0 is the floor, edge 8 the ceiling.
    function automatic int ref_edge_khz(int idx);
        case (idx)
            0: return 10000;
            1: return 12500;
            2: return 15000;
            3: return 20000;
            4: return 25000;
            5: return 50000;
            6: return 75000;
            7: return 100000;
            default: return 125000;
        endcase
    endfunction

endpackage

// File: rtl/pll_cfg_seq_classify.sv
// Classifier: validates a latched request and derives range bits and gains.
// Purely combinational; assumes inputs are held stable while it is consulted.
module pll_cfg_seq_classify
    import pll_cfg_seq_pkg::*;
#(
    parameter int TGT_W  = 13,
    parameter int PAR_W  = 18,
    parameter int PDIV_W = 4
) (
    input  logic [TGT_W-1:0]  tgt_mhz,
    input  logic [PAR_W-1:0]  parent_khz,
    input  logic [PDIV_W-1:0] pre_div,
    output logic              vco_ok,
    output logic              ref_ok,
    output logic              lo_rng,
    output logic              hi_rng,
    output logic [KP_W-1:0]   kp,
    output logic [KI_W-1:0]   ki
);
    localparam int REF_W = PAR_W + 1;

    logic [REF_W-1:0]  ref_khz;
    logic [REF_W-1:0]  divisor;
    logic [2:0]        col;
    gain_row_t         row;

    // Reference frequency and its band column.
    always_comb begin
        divisor = (pre_div == '0) ? REF_W'(1) : REF_W'(pre_div);
        ref_khz = (pre_div == '0) ? {parent_khz, 1'b0} : ({1'b0, parent_khz} / divisor);
        col = 3'd0;
        for (int i = 1; i < 8; i++) begin
            if (ref_khz >= REF_W'(ref_edge_khz(i))) col = 3'(i);
        end
        ref_ok = (ref_khz >= REF_W'(ref_edge_khz(0))) && (ref_khz < REF_W'(ref_edge_khz(8)));
    end

    // VCO band, range bits and gains.
    always_comb begin
        vco_ok = (tgt_mhz >= TGT_W'(VCO_MIN_MHZ)) && (tgt_mhz < TGT_W'(VCO_MAX_MHZ));
        lo_rng = tgt_mhz < TGT_W'(VCO_LOW_MHZ);
        hi_rng = tgt_mhz >= TGT_W'(VCO_HIGH_MHZ);
        if (tgt_mhz < TGT_W'(VCO_HIGH_MHZ))     row = ROW_MID;
        else if (tgt_mhz < TGT_W'(VCO_TOP_MHZ)) row = ROW_HIGH;
        else                                    row = ROW_TOP;
        ki = hi_rng ? KI_W'(3) : KI_W'(4);
        kp = kp_lookup(row, col);
    end

endmodule

// File: rtl/pll_cfg_seq_poll.sv
// Lock poller: samples lock every WAIT_CYC cycles, at most LOCK_TRIES times.
// Outputs are combinational flags valid only while run is high.
module pll_cfg_seq_poll #(
    parameter int WAIT_CYC   = 8,
    parameter int LOCK_TRIES = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    input  logic lock_in,
    output logic locked,
    output logic expired
);
    localparam int WCNT_W = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;
    localparam int TRY_W  = (LOCK_TRIES > 1) ? $clog2(LOCK_TRIES) : 1;

    logic [WCNT_W-1:0] wcnt;
    logic [TRY_W-1:0]  tries;
    logic              sample;

    // Sample point and outcome flags.
    always_comb begin
        sample  = run && (wcnt == WCNT_W'(WAIT_CYC - 1));
        locked  = sample && lock_in;
        expired = sample && !lock_in && (tries == TRY_W'(LOCK_TRIES - 1));
    end

    // Interval and try counters.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wcnt  <= '0;
            tries <= '0;
        end else if (sample) begin
            wcnt  <= '0;
            tries <= tries + TRY_W'(1);
        end else if (run) begin
            wcnt  <= wcnt + WCNT_W'(1);
        end
    end

endmodule

// File: rtl/pll_cfg_seq.sv
// Top: sequences a synthesizer through power-up, reset, range, divider and
// gain loading, then polls lock; also runs an isolation-ordered power-down.
// Assumes request inputs are valid in the cycle cfg_req is high.
module pll_cfg_seq
    import pll_cfg_seq_pkg::*;
#(
    parameter int TGT_W      = 13,
    parameter int NINT_W     = 10,
    parameter int NFRAC_W    = 20,
    parameter int PDIV_W     = 4,
    parameter int PAR_W      = 18,
    parameter int WAIT_CYC   = 8,
    parameter int LOCK_TRIES = 100,
    parameter bit HAS_FRAC   = 1'b1,
    parameter bit ALWAYS_ON  = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_req,
    input  logic               dis_req,
    input  logic [TGT_W-1:0]   tgt_mhz,
    input  logic [NINT_W-1:0]  fb_int,
    input  logic [NFRAC_W-1:0] fb_frac,
    input  logic [PDIV_W-1:0]  pre_div,
    input  logic [PAR_W-1:0]   parent_khz,
    input  logic               lock_in,
    output logic               pwr_on,
    output logic               iso_on,
    output logic               gate_en,
    output logic               rst_main_n,
    output logic               rst_post_n,
    output logic               vco_hi_clr,
    output logic               vco_low_rng,
    output logic               vco_high_rng,
    output logic [NINT_W-1:0]  fb_int_o,
    output logic [NFRAC_W-1:0] fb_frac_o,
    output logic [PDIV_W-1:0]  pre_div_o,
    output logic [3:0]         kp_o,
    output logic [2:0]         ki_o,
    output logic [2:0]         ka_o,
    output logic               busy,
    output logic               done,
    output logic               err,
    output logic [1:0]         err_code
);
    seq_state_t         state;
    logic [TGT_W-1:0]   tgt_q;
    logic [NINT_W-1:0]  int_q;
    logic [NFRAC_W-1:0] frac_q;
    logic [PDIV_W-1:0]  pdiv_q;
    logic [PAR_W-1:0]   par_q;
    logic               vco_ok, ref_ok, lo_rng, hi_rng;
    logic [KP_W-1:0]    kp_c;
    logic [KI_W-1:0]    ki_c;
    logic               locked, expired;
    logic               dis_ok;

    assign ka_o = '0;

    // Disable acceptance depends on the always-on variant.
    if (ALWAYS_ON) begin : g_aon
        assign dis_ok = 1'b0;
    end else begin : g_sw
        assign dis_ok = dis_req;
    end

    pll_cfg_seq_classify #(.TGT_W(TGT_W), .PAR_W(PAR_W), .PDIV_W(PDIV_W)) cls_i (
        .tgt_mhz(tgt_q), .parent_khz(par_q), .pre_div(pdiv_q),
        .vco_ok(vco_ok), .ref_ok(ref_ok), .lo_rng(lo_rng), .hi_rng(hi_rng),
        .kp(kp_c), .ki(ki_c)
    );

    pll_cfg_seq_poll #(.WAIT_CYC(WAIT_CYC), .LOCK_TRIES(LOCK_TRIES)) poll_i (
        .clk(clk), .rst_n(rst_n), .clear(state == ST_REL), .run(state == ST_WAIT),
        .lock_in(lock_in), .locked(locked), .expired(expired)
    );

    // Fractional divider register exists only in the fractional variant.
    if (HAS_FRAC) begin : g_frac
        always_ff @(posedge clk) begin
            if (!rst_n)               fb_frac_o <= '0;
            else if (state == ST_DIV) fb_frac_o <= frac_q;
        end
    end else begin : g_nofrac
        assign fb_frac_o = '0;
    end

    // Main sequencer: one control action per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            {tgt_q, int_q, frac_q, pdiv_q, par_q} <= '0;
            pwr_on <= 1'b0;  iso_on <= 1'b1;  gate_en <= 1'b0;
            rst_main_n <= 1'b0;  rst_post_n <= 1'b0;  vco_hi_clr <= 1'b0;
            vco_low_rng <= 1'b0;  vco_high_rng <= 1'b0;
            fb_int_o <= '0;  pre_div_o <= '0;  kp_o <= '0;  ki_o <= '0;
            busy <= 1'b0;  done <= 1'b0;  err <= 1'b0;  err_code <= ERR_NONE;
        end else begin
            done <= 1'b0;
            err <= 1'b0;
            vco_hi_clr <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (cfg_req) begin
                        tgt_q <= tgt_mhz;  int_q <= fb_int;  frac_q <= fb_frac;
                        pdiv_q <= pre_div;  par_q <= parent_khz;
                        busy <= 1'b1;
                        state <= ST_CHECK;
                    end else if (dis_ok) begin
                        busy <= 1'b1;
                        state <= ST_PD_GATE;
                    end
                end
                ST_CHECK: begin
                    if (!vco_ok || !ref_ok) begin
                        err <= 1'b1;
                        err_code <= !vco_ok ? ERR_VCO : ERR_REF;
                        busy <= 1'b0;
                        state <= ST_IDLE;
                    end else begin
                        state <= ST_PWR;
                    end
                end
                ST_PWR:  begin pwr_on <= 1'b1; iso_on <= 1'b0; state <= ST_GATE; end
                ST_GATE: begin gate_en <= 1'b1; state <= ST_RST; end
                ST_RST:  begin rst_main_n <= 1'b0; rst_post_n <= 1'b0; state <= ST_VCLR; end
                ST_VCLR: begin vco_hi_clr <= 1'b1; state <= ST_VRNG; end
                ST_VRNG: begin
                    vco_low_rng <= lo_rng;
                    vco_high_rng <= hi_rng;
                    state <= ST_DIV;
                end
                ST_DIV:  begin fb_int_o <= int_q; pre_div_o <= pdiv_q; state <= ST_GAIN; end
                ST_GAIN: begin kp_o <= kp_c; ki_o <= ki_c; state <= ST_REL; end
                ST_REL:  begin rst_main_n <= 1'b1; rst_post_n <= 1'b1; state <= ST_WAIT; end
                ST_WAIT: begin
                    if (locked) begin
                        done <= 1'b1;  err_code <= ERR_NONE;  busy <= 1'b0;
                        state <= ST_IDLE;
                    end else if (expired) begin
                        err <= 1'b1;  err_code <= ERR_LOCK;  busy <= 1'b0;
                        state <= ST_IDLE;
                    end
                end
                ST_PD_GATE: begin gate_en <= 1'b0; state <= ST_PD_ISO; end
                ST_PD_ISO:  begin iso_on <= 1'b1; state <= ST_PD_PWR; end
                ST_PD_PWR:  begin
                    pwr_on <= 1'b0;  done <= 1'b1;  err_code <= ERR_NONE;  busy <= 1'b0;
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pll_cfg_seq_chk.sv
// Checker: ordering and handshake properties over the top-level ports.
// Assumes a synchronous active-low reset held for at least one clock.
module pll_cfg_seq_chk #(
    parameter bit ALWAYS_ON = 1'b0
) (
    input logic       clk,
    input logic       rst_n,
    input logic       pwr_on,
    input logic       iso_on,
    input logic       gate_en,
    input logic       rst_main_n,
    input logic       rst_post_n,
    input logic       vco_hi_clr,
    input logic [3:0] kp_o,
    input logic       busy,
    input logic       done,
    input logic       err,
    input logic [1:0] err_code
);
    // R6: power comes up with isolation already cleared.
    a_r6_pwr_deiso: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_on) |-> !iso_on);
    // R6: gate opens only on a powered, de-isolated core.
    a_r6_gate_after_pwr: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_en) |-> (pwr_on && !iso_on));
    // R6: upper word cleared while both resets are held.
    a_r6_clear_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        vco_hi_clr |-> (!rst_main_n && !rst_post_n));
    // R6: both resets leave together, after gains are loaded.
    a_r6_release_loaded: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_main_n) |-> (rst_post_n && gate_en && kp_o != 4'd0));
    // R8: isolation is raised only after the gate is closed.
    a_r8_gate_before_iso: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(iso_on) |-> !gate_en);
    // R8: power drops only with isolation held from before.
    a_r8_iso_before_off: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_on) |-> (iso_on && $past(iso_on)));
    // R10: done is a single-cycle pulse.
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R10: done and err never coincide.
    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));
    // R10: busy ends only with a completing pulse.
    a_r10_busy_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (done || err));
    // R1: a range error leaves the control pins untouched.
    a_r1_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (err && err_code == 2'd1) |-> ($stable(pwr_on) && $stable(gate_en) && $stable(rst_main_n)));

    // R9: the always-on variant never removes power.
    if (ALWAYS_ON) begin : g_aon_chk
        a_r9_never_off: assert property (@(posedge clk) disable iff (!rst_n)
            !$fell(pwr_on));
    end
endmodule

bind pll_cfg_seq pll_cfg_seq_chk #(.ALWAYS_ON(ALWAYS_ON)) chk_i (
    .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .iso_on(iso_on), .gate_en(gate_en),
    .rst_main_n(rst_main_n), .rst_post_n(rst_post_n), .vco_hi_clr(vco_hi_clr),
    .kp_o(kp_o), .busy(busy), .done(done), .err(err), .err_code(err_code)
);

// File: tb/pll_cfg_seq_tb_top.sv
// Bench: directed corners plus seeded random requests, with expected values
// computed by bench functions; two variants share all inputs.
module pll_cfg_seq_tb_top;
    localparam int W = 3;
    localparam int TRIES = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_req = 1'b0, dis_req = 1'b0, lock_in = 1'b0;
    logic [12:0] tgt_mhz = '0;
    logic [9:0]  fb_int = '0;
    logic [19:0] fb_frac = '0;
    logic [3:0]  pre_div = '0;
    logic [17:0] parent_khz = '0;

    logic pwr_on, iso_on, gate_en, rst_main_n, rst_post_n, vco_hi_clr, vco_low_rng, vco_high_rng;
    logic [9:0] fb_int_o; logic [19:0] fb_frac_o; logic [3:0] pre_div_o, kp_o;
    logic [2:0] ki_o, ka_o; logic busy, done, err; logic [1:0] err_code;

    logic a_pwr, a_iso, a_gate, a_rm, a_rp, a_clr, a_lo, a_hi;
    logic [9:0] a_int; logic [19:0] a_frac; logic [3:0] a_pdiv, a_kp;
    logic [2:0] a_ki, a_ka; logic a_busy, a_done, a_err; logic [1:0] a_code;

    int n_chk = 0, n_bad = 0, cyc = 0;

    always #2.5 clk = ~clk;

    pll_cfg_seq #(.WAIT_CYC(W), .LOCK_TRIES(TRIES), .HAS_FRAC(1'b1), .ALWAYS_ON(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_req(cfg_req), .dis_req(dis_req), .tgt_mhz(tgt_mhz),
        .fb_int(fb_int), .fb_frac(fb_frac), .pre_div(pre_div), .parent_khz(parent_khz),
        .lock_in(lock_in), .pwr_on(pwr_on), .iso_on(iso_on), .gate_en(gate_en),
        .rst_main_n(rst_main_n), .rst_post_n(rst_post_n), .vco_hi_clr(vco_hi_clr),
        .vco_low_rng(vco_low_rng), .vco_high_rng(vco_high_rng), .fb_int_o(fb_int_o),
        .fb_frac_o(fb_frac_o), .pre_div_o(pre_div_o), .kp_o(kp_o), .ki_o(ki_o), .ka_o(ka_o),
        .busy(busy), .done(done), .err(err), .err_code(err_code));

    pll_cfg_seq #(.WAIT_CYC(W), .LOCK_TRIES(TRIES), .HAS_FRAC(1'b0), .ALWAYS_ON(1'b1)) dut_aon_i (
        .clk(clk), .rst_n(rst_n), .cfg_req(cfg_req), .dis_req(dis_req), .tgt_mhz(tgt_mhz),
        .fb_int(fb_int), .fb_frac(fb_frac), .pre_div(pre_div), .parent_khz(parent_khz),
        .lock_in(lock_in), .pwr_on(a_pwr), .iso_on(a_iso), .gate_en(a_gate),
        .rst_main_n(a_rm), .rst_post_n(a_rp), .vco_hi_clr(a_clr),
        .vco_low_rng(a_lo), .vco_high_rng(a_hi), .fb_int_o(a_int),
        .fb_frac_o(a_frac), .pre_div_o(a_pdiv), .kp_o(a_kp), .ki_o(a_ki), .ka_o(a_ka),
        .busy(a_busy), .done(a_done), .err(a_err), .err_code(a_code));

    task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    function automatic int e_ref(int par, int pd);
        return (pd == 0) ? par * 2 : par / pd;
    endfunction

    function automatic int e_err(int t, int par, int pd);
        int r = e_ref(par, pd);
        if (t < 700 || t >= 4000) return 1;
        if (r < 10000 || r >= 125000) return 2;
        return 0;
    endfunction

    function automatic int e_kp(int t, int r);
        int up[7] = '{12500, 15000, 20000, 25000, 50000, 75000, 100000};
        int mid[8] = '{5, 6, 6, 7, 7, 8, 9, 10};
        int hig[8] = '{4, 4, 5, 5, 6, 7, 8, 9};
        int top[8] = '{4, 5, 5, 6, 7, 8, 9, 10};
        int c = 0;
        foreach (up[i]) if (r >= up[i]) c++;
        if (t < 2200) return mid[c];
        if (t < 3100) return hig[c];
        return top[c];
    endfunction

    // One configuration request, observed cycle by cycle.
    task automatic do_cfg(int t, int par, int pd, int nint, int nfrac, int dly, bit poke);
        int ee = e_err(t, par, pd);
        int n = 0, m, it = 0;
        bit rel = 0, saw_clr = 0, p_gate, p_rst;
        logic [31:0] snap, now;
        @(negedge clk);
        tgt_mhz = 13'(t); parent_khz = 18'(par); pre_div = 4'(pd);
        fb_int = 10'(nint); fb_frac = 20'(nfrac); cfg_req = 1'b1;
        snap = {pwr_on, iso_on, gate_en, rst_main_n, rst_post_n, vco_low_rng, vco_high_rng,
                kp_o, ki_o, fb_int_o, pre_div_o};
        p_gate = gate_en; p_rst = rst_main_n;
        @(negedge clk);
        cfg_req = 1'b0;
        chk(busy == 1'b1, "R10 busy after accept", busy, 1);
        while (it < 3000) begin
            if (gate_en && !p_gate) chk(pwr_on && !iso_on, "R6 gate after power", gate_en, 1);
            if (!rst_main_n && p_rst) chk(gate_en, "R6 reset after gate", gate_en, 1);
            if (vco_hi_clr) begin
                chk(!rst_main_n && !rst_post_n, "R6 clear under reset", rst_main_n, 0);
                saw_clr = 1;
            end
            if (rst_main_n && !p_rst) begin
                chk(saw_clr && rst_post_n, "R6 release after clear", saw_clr, 1);
                rel = 1; n = 0;
            end else if (rel) n++;
            lock_in = rel && (n >= dly);
            if (done || err) break;
            p_gate = gate_en; p_rst = rst_main_n;
            if (poke && it == 2) begin tgt_mhz = 13'd3500; cfg_req = 1'b1; end
            if (poke && it == 3) cfg_req = 1'b0;
            it++;
            @(negedge clk);
        end
        if (ee != 0) begin
            now = {pwr_on, iso_on, gate_en, rst_main_n, rst_post_n, vco_low_rng, vco_high_rng,
                   kp_o, ki_o, fb_int_o, pre_div_o};
            chk(err && err_code == 2'(ee), (ee == 1) ? "R1 range error" : "R2 reference error",
                err_code, ee);
            chk(now == snap, (ee == 1) ? "R1 outputs kept" : "R2 outputs kept", now, snap);
        end else begin
            m = (dly + W) / W;
            if (m > TRIES)
                chk(err && err_code == 2'd3 && n == TRIES * W, "R7 lock timeout", n, TRIES * W);
            else
                chk(done && n == m * W, "R7 lock sample time", n, m * W);
            chk(kp_o == 4'(e_kp(t, e_ref(par, pd))), "R4 kp", kp_o, e_kp(t, e_ref(par, pd)));
            chk(ki_o == ((t < 2200) ? 3'd4 : 3'd3) && ka_o == 3'd0, "R3 ki/ka", ki_o, (t < 2200) ? 4 : 3);
            chk(vco_low_rng == (t < 1200) && vco_high_rng == (t >= 2200), "R5 range bits",
                {vco_low_rng, vco_high_rng}, {(t < 1200), (t >= 2200)});
            chk(fb_int_o == 10'(nint) && pre_div_o == 4'(pd) && fb_frac_o == 20'(nfrac),
                "R11 dividers", fb_frac_o, nfrac);
            chk(a_frac == 20'd0, "R11 no fraction variant", a_frac, 0);
        end
        @(negedge clk);
        chk(!done && !err && !busy, "R10 single pulse", {done, err, busy}, 0);
        lock_in = 1'b0;
    endtask

    // Power-down request on both variants.
    task automatic do_off();
        bit p_gate, p_iso, p_pwr, a_seen = 0;
        int it = 0;
        @(negedge clk);
        dis_req = 1'b1;
        p_gate = gate_en; p_iso = iso_on; p_pwr = pwr_on;
        @(negedge clk);
        dis_req = 1'b0;
        chk(busy == 1'b1, "R8 busy on disable", busy, 1);
        while (it < 50) begin
            if (a_busy) a_seen = 1;
            if (!gate_en && p_gate) chk(pwr_on && !iso_on, "R8 ungate first", iso_on, 0);
            if (iso_on && !p_iso) chk(!gate_en && pwr_on, "R8 isolate before off", gate_en, 0);
            if (!pwr_on && p_pwr) chk(iso_on, "R8 isolation held", iso_on, 1);
            if (done) break;
            p_gate = gate_en; p_iso = iso_on; p_pwr = pwr_on;
            it++;
            @(negedge clk);
        end
        chk(done && !pwr_on && iso_on && !gate_en, "R8 final off state", pwr_on, 0);
        chk(a_pwr == 1'b1 && !a_seen, "R9 always-on ignores disable", a_pwr, 1);
        @(negedge clk);
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20251));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!pwr_on && iso_on && !gate_en && !rst_main_n && !rst_post_n, "R12 reset pins",
            {pwr_on, iso_on, gate_en}, 3'b010);
        chk(kp_o == 0 && ki_o == 0 && !vco_low_rng && !vco_high_rng && !busy && !done && !err,
            "R12 reset values", kp_o, 0);

        do_cfg(699, 25000, 1, 10, 5, 0, 0);
        do_cfg(4000, 25000, 1, 10, 5, 0, 0);
        do_cfg(700, 10000, 1, 40, 7, 0, 0);
        do_cfg(1199, 12500, 1, 41, 8, 1, 0);
        do_cfg(1200, 9999, 1, 42, 9, 1, 0);
        do_cfg(1200, 5000, 0, 43, 10, 2, 0);
        do_cfg(2199, 124999, 1, 44, 11, 2, 0);
        do_cfg(2200, 125000, 1, 45, 12, 2, 0);
        do_cfg(2200, 62000, 0, 46, 13, 3, 0);
        do_cfg(3099, 100000, 4, 47, 14, 4, 0);
        do_cfg(3100, 130000, 3, 48, 15, 5, 0);
        do_cfg(3999, 80000, 1, 49, 16, 0, 0);
        do_cfg(2500, 20000, 1, 50, 17, 1000, 0);
        do_cfg(1500, 20000, 1, 51, 18, TRIES * W - 1, 0);
        do_cfg(900, 30000, 2, 52, 19, 1, 1);
        chk(vco_low_rng == 1'b1 && ki_o == 3'd4, "R10 request while busy ignored", vco_high_rng, 0);
        do_off();
        do_cfg(1800, 45000, 1, 53, 20, 2, 0);

        for (int k = 0; k < 40; k++) begin
            int t = 600 + int'($urandom % 3600);
            int par = 3000 + int'($urandom % 140000);
            int pd = int'($urandom % 8);
            do_cfg(t, par, pd, int'($urandom % 1024), int'($urandom % 1048576),
                   int'($urandom % 8), 0);
            if (pwr_on && ($urandom % 6) == 0) do_off();
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule